// File: doc/BRIEF.md
# Cascaded Synchronous Binary Counter

The block is a synchronous binary up-counter built from a parameterised chain of 4-bit stages. Each stage has a synchronous clear, a synchronous parallel load and two count enables. A stage advances only when both of its enables are high. The first stage takes both enables from the block's inputs. Every later stage shares the first enable and takes its second enable from the carry of the stage below it. The chain therefore behaves as one wide binary counter, and the carry of the top stage is presented at the block's edge so that further blocks can be chained.

All state changes occur on the rising clock edge. Because load and clear are synchronous, surrounding logic can feed the carry back into the load input with a fixed preset, which gives a counter that starts at an offset. Surrounding logic can instead decode a terminal value onto the clear input, which gives a counter that ends early. Both uses depend only on the ports of the block.

Top module: `cascade_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` becomes all zeros on that edge, whatever the other inputs are.
- R2: When `rst` is low and `clr_n` is low at a rising edge, `count` becomes all zeros, even if `load_n` is low or both enables are high.
- R3: When `rst` is low, `clr_n` is high and `load_n` is low at a rising edge, `count` takes `load_val` bit for bit, with bit 0 as the least significant bit and the top bit as the most significant. This happens whatever the enables are.
- R4: When `rst` is low and `clr_n` and `load_n` are both high, `count` increases by one on the edge only if `en_p` and `en_t` are both high. Otherwise `count` holds its value.
- R5: `carry_out` is combinational. It is high exactly when `count` is all ones and `en_t` is high, and it does not depend on `en_p`.
- R6: The count is made of 4-bit stages. A stage above the lowest advances only when every stage below it is all ones and counting is enabled. An all-ones count wraps to all zeros on the next counting edge.
- R7: If `load_n` is driven with the inverse of `carry_out` and `load_val` holds a fixed preset, the count runs from the preset up to all ones and then restarts at the preset.
- R8: If `clr_n` is driven low while `count` equals a chosen terminal value, the count runs from zero up to that value and returns to zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Count enable of the lowest stage; also qualifies the carry |
| load_val | input | STAGES*STAGE_W | Parallel load value |
| count | output | STAGES*STAGE_W | Current count |
| carry_out | output | 1 | High when the count is all ones and `en_t` is high |

## Verification
The count register is also the output, so a wrong next-state decision shows on `count` at the first sample after the edge where it happened. A broken link between stages shows only when the lower nibble passes through 1111: an upper nibble that fails to step, or that steps too early, is exposed on the transitions 0F to 10, FF to 00 and F7 to F8. Errors in carry gating show at once, because `carry_out` is checked while the count is all ones with each enable held low in turn. The two feedback loops run through many wraps to show that the preset and terminal values repeat.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Number of bits in one cascade stage
    localparam int unsigned NIBBLE_W = 4;

    // What a stage does on the coming edge, in priority order
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    // Control inputs seen by one stage
    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } ctl_t;

    // Priority: clear, then load, then count, then hold
    function automatic act_e decide(input ctl_t c);
        if (!c.clr_n)
            return ACT_CLEAR;
        else if (!c.load_n)
            return ACT_LOAD;
        else if (c.en_p && c.en_t)
            return ACT_COUNT;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/stage_ctrl.sv
module stage_ctrl
    import cnt_pkg::*;
(
    input  ctl_t ctl,
    input  logic at_top,
    output act_e act,
    output logic rco
);

    always_comb begin
        act = decide(ctl);
    end

    // Carry is qualified only by the T-side enable
    always_comb begin
        rco = at_top & ctl.en_t;
    end

endmodule

// File: rtl/count_stage.sv
module count_stage
    import cnt_pkg::*;
#(
    parameter int unsigned W = NIBBLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         rco
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = W'(1);

    act_e act;
    logic at_top;

    always_comb begin
        at_top = (q == ALL_ONES);
    end

    stage_ctrl u_ctrl (
        .ctl    (ctl),
        .at_top (at_top),
        .act    (act),
        .rco    (rco)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_CLEAR: q <= '0;
                ACT_LOAD:  q <= din;
                ACT_COUNT: q <= q + ONE;
                default:   q <= q;
            endcase
        end
    end

    // R2: clear wins over load and count
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !ctl.clr_n |=> (q == '0));

    // R3: load takes the data when clear is idle
    assert_load_data_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_n && !ctl.load_n) |=> (q == $past(din)));

    // R4: count steps by one when both enables are high
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_n && ctl.load_n && ctl.en_p && ctl.en_t) |=> (q == $past(q) + ONE));

    // R4: otherwise the stage holds
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_n && ctl.load_n && !(ctl.en_p && ctl.en_t)) |=> $stable(q));

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned STAGE_W = NIBBLE_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        en_p,
    input  logic                        en_t,
    input  logic [STAGES*STAGE_W-1:0]   load_val,
    output logic [STAGES*STAGE_W-1:0]   count,
    output logic                        carry_out
);

    localparam int unsigned TOTAL_W = STAGES * STAGE_W;

    logic [STAGES-1:0]  rco;
    logic [STAGES-1:0]  t_in;
    logic [STAGE_W-1:0] stage_q [STAGES];

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            ctl_t ctl;

            // The lowest stage takes the block's T enable; higher stages
            // take the carry of the stage beneath them.
            if (k == 0) begin : g_first
                always_comb t_in[k] = en_t;
            end else begin : g_chain
                always_comb t_in[k] = rco[k-1];
            end

            always_comb begin
                ctl.clr_n  = clr_n;
                ctl.load_n = load_n;
                ctl.en_p   = en_p;
                ctl.en_t   = t_in[k];
            end

            count_stage #(.W(STAGE_W)) u_stage (
                .clk (clk),
                .rst (rst),
                .ctl (ctl),
                .din (load_val[k*STAGE_W +: STAGE_W]),
                .q   (stage_q[k]),
                .rco (rco[k])
            );

            always_comb count[k*STAGE_W +: STAGE_W] = stage_q[k];

            if (k > 0) begin : g_chk
                // R6: an upper stage only moves through counting when the
                // stage below carries and the shared enable is high
                assert_cascade_gate_R6: assert property (@(posedge clk) disable iff (rst)
                    (!$past(rst) && $past(clr_n) && $past(load_n)
                     && (stage_q[k] != $past(stage_q[k])))
                    |-> $past(rco[k-1] && en_p));
            end
        end
    endgenerate

    always_comb carry_out = rco[STAGES-1];

    // R5: carry only while the whole count is all ones and en_t is high
    assert_carry_full_R5: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> ((count == {TOTAL_W{1'b1}}) && en_t));

    // R1: reset clears the count on the next edge
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count == '0));

endmodule

// File: tb/cascade_counter_test.sv
module cascade_counter_test;

    localparam int STAGES  = 2;
    localparam int STAGE_W = 4;
    localparam int TW      = STAGES * STAGE_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_n = 1'b1;
    logic          load_n = 1'b1;
    logic          en_p = 1'b0;
    logic          en_t = 1'b0;
    logic [TW-1:0] load_val = '0;
    logic [TW-1:0] count;
    logic          carry_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cascade_counter #(.STAGES(STAGES), .STAGE_W(STAGE_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .en_p      (en_p),
        .en_t      (en_t),
        .load_val  (load_val),
        .count     (count),
        .carry_out (carry_out)
    );

    typedef struct packed {
        logic          c_n;
        logic          l_n;
        logic          p;
        logic          t;
        logic [TW-1:0] d;
        logic [TW-1:0] exp_q;
        logic          exp_c;
    } vec_t;

    // Each row: inputs applied for one edge, then count and carry expected
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0}, // R3 load, enables low
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hA6, 1'b0}, // R4 count
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hA6, 1'b0}, // R4 hold, en_p low
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hA6, 1'b0}, // R4 hold, en_t low
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h0E, 8'h0E, 1'b0}, // R3 load over count
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0}, // R5 low nibble full only
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // R6 carry into upper nibble
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hFE, 8'hFE, 1'b0}, // R3 load
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // R5 carry high
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}, // R5 carry ignores en_p
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0}, // R5 carry gated by en_t
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R6 wrap to zero
        '{1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 8'h00, 1'b0}, // R2 clear over load
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C, 1'b0}, // R3 bit mapping
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R2 clear over count
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'hF7, 8'hF7, 1'b0}, // R3 load
        '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hF8, 1'b0}  // R6 upper nibble holds
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] model;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(count == 8'h00, "R1 reset", count, 8'h00);
        check(carry_out == 1'b0, "R5 carry in reset", carry_out, 0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            clr_n    = VECS[i].c_n;
            load_n   = VECS[i].l_n;
            en_p     = VECS[i].p;
            en_t     = VECS[i].t;
            load_val = VECS[i].d;
            @(negedge clk);
            check(count == VECS[i].exp_q, $sformatf("vector %0d count", i), count, VECS[i].exp_q);
            check(carry_out == VECS[i].exp_c, $sformatf("vector %0d carry", i), carry_out, VECS[i].exp_c);
        end

        // R1: reset beats load
        rst = 1'b1; load_n = 1'b0; load_val = 8'h77; en_p = 1'b1; en_t = 1'b1;
        @(negedge clk);
        check(count == 8'h00, "R1 reset over load", count, 8'h00);
        rst = 1'b0; load_n = 1'b1;

        // R7: carry fed back to load with preset F6
        load_val = 8'hF6; load_n = 1'b0; en_p = 1'b1; en_t = 1'b1;
        @(negedge clk);
        model = 8'hF6;
        check(count == model, "R7 preset start", count, model);
        for (int c = 0; c < 30; c++) begin
            load_n = ~carry_out;
            @(negedge clk);
            model = (model == 8'hFF) ? 8'hF6 : model + 8'h01;
            check(count == model, "R7 offset sequence", count, model);
        end
        load_n = 1'b1;

        // R8: terminal value 0D decoded onto clear
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = 8'h00;
        for (int c = 0; c < 32; c++) begin
            clr_n = (count != 8'h0D);
            @(negedge clk);
            model = (model == 8'h0D) ? 8'h00 : model + 8'h01;
            check(count == model, "R8 early end sequence", count, model);
        end
        clr_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule